// File: doc/BRIEF.md
# Accumulator and Carry-Flag Operation Unit

This block executes four single-operand operations on an 8-bit accumulator and its 8-bit flag byte: bitwise inversion of the accumulator, two's-complement negation, inversion of the carry flag, and forcing the carry flag to one. A 2-bit selector picks the operation. Each operation writes its own subset of flags and keeps the remaining flags as they were.

The caller presents the accumulator, the flag byte and the selector, and raises `op_valid` for one cycle. On the next clock edge the block registers the new accumulator, the new flag byte and the number of clock states the operation takes. It raises `res_valid` for that one cycle. A sequencer can read the state count to decide when the next operation may start. While `op_valid` is low, the registered outputs hold their values.

Flag byte layout, from bit 7 down to bit 0:
- bit 7: sign
- bit 6: zero
- bit 5: spare
- bit 4: half-carry
- bit 3: spare
- bit 2: parity/overflow
- bit 1: subtract
- bit 0: carry

The two spare bits always pass through unchanged.

Top module: `acc_flag_unit`

## Requirements
- R1: With selector 00 (invert), `acc_out` is the bitwise inverse of `acc_in`. Flag bits 4 (half-carry) and 1 (subtract) are set. Bits 7, 6, 5, 3, 2 and 0 are copied from `flags_in`.
- R2: With selector 01 (negate), `acc_out` is (0 − `acc_in`) mod 256. The flags are set as follows:
  - bit 7 is bit 7 of the result;
  - bit 6 is set only if the result is zero;
  - bit 1 is set;
  - bit 4 is set when the low nibble of `acc_in` is non-zero (borrow out of bit 3);
  - bits 5 and 3 are copied.
- R3: With selector 01, an input of 80h returns 80h. Bit 2 (parity/overflow) is set only when the input was 80h and is cleared for every other input.
- R4: With selector 01, bit 0 (carry) is set exactly when `acc_in` is non-zero.
- R5: With selector 10 (carry invert), bit 0 becomes the inverse of the incoming carry. Bit 4 takes the incoming carry and bit 1 is cleared. `acc_out` equals `acc_in`, and bits 7, 6, 5, 3 and 2 are copied.
- R6: With selector 11 (carry set), bit 0 is set and bits 4 and 1 are cleared. `acc_out` equals `acc_in`, and the other flag bits are copied.
- R7: `op_states` reports 8 for negate and 4 for each of the other three operations. It is registered together with the result.
- R8: All outputs update on the clock edge that samples `op_valid` high. `res_valid` is high for exactly the cycle after each accepted operation, and back-to-back operations each produce their own result.
- R9: While `op_valid` is low, `acc_out`, `flags_out` and `op_states` hold their values whatever the other inputs do, and `res_valid` is low.
- R10: A synchronous reset clears `acc_out`, `flags_out`, `op_states` and `res_valid` to zero. Reset takes priority over `op_valid` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation strobe |
| op_sel | input | 2 | 00 invert, 01 negate, 10 carry invert, 11 carry set |
| acc_in | input | 8 | Current accumulator |
| flags_in | input | 8 | Current flag byte |
| acc_out | output | 8 | Registered new accumulator |
| flags_out | output | 8 | Registered new flag byte |
| op_states | output | 4 | Registered clock-state count of the operation |
| res_valid | output | 1 | High for one cycle when a new result is present |

## Verification
Two functions can fall in the same cycle in this block:
- **Reset and an operation strobe.** The bench raises reset while `op_valid` is high with a negate of a non-zero value pending. It judges the cycle by all outputs reading zero, not the negate result.
- **Presenting one result and accepting the next operation.** The bench holds `op_valid` high for two consecutive cycles with different selectors. It judges by the first result appearing intact in the first cycle and being replaced by the second result, including a state count that drops from 8 to 4, in the next.

// File: rtl/afu_pkg.sv
package afu_pkg;

  localparam int FLAG_W = 8;

  // Bit positions inside the flag byte; the carry/half-carry copy relies on them.
  localparam int FLAG_S  = 7;
  localparam int FLAG_Z  = 6;
  localparam int FLAG_H  = 4;
  localparam int FLAG_PV = 2;
  localparam int FLAG_N  = 1;
  localparam int FLAG_C  = 0;

  typedef enum logic [1:0] {
    OP_INV  = 2'b00,
    OP_NEG  = 2'b01,
    OP_CINV = 2'b10,
    OP_CSET = 2'b11
  } afu_op_e;

  // Field order mirrors the bit positions above, MSB first.
  typedef struct packed {
    logic s;
    logic z;
    logic spare5;
    logic h;
    logic spare3;
    logic pv;
    logic n;
    logic c;
  } afu_flags_t;

endpackage

// File: rtl/afu_negate.sv
module afu_negate #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] value_in,
  output logic [DATA_W-1:0] neg_res,
  output logic              neg_sign,
  output logic              neg_zero,
  output logic              neg_half_borrow,
  output logic              neg_min_in,
  output logic              neg_borrow
);

  localparam int NIB_W = 4;
  localparam logic [DATA_W-1:0] MIN_VAL = {1'b1, {(DATA_W-1){1'b0}}};

  function automatic logic [DATA_W-1:0] f_negate(input logic [DATA_W-1:0] v);
    return (~v) + {{(DATA_W-1){1'b0}}, 1'b1};
  endfunction

  // Subtracting from zero borrows out of the low nibble whenever it is non-zero.
  function automatic logic f_half_borrow(input logic [DATA_W-1:0] v);
    return |v[NIB_W-1:0];
  endfunction

  always_comb begin
    neg_res         = f_negate(value_in);
    neg_sign        = neg_res[DATA_W-1];
    neg_zero        = ~|neg_res;
    neg_half_borrow = f_half_borrow(value_in);
    neg_min_in      = (value_in == MIN_VAL);
    neg_borrow      = |value_in;
  end

endmodule

// File: rtl/afu_invert.sv
module afu_invert #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] value_in,
  output logic [DATA_W-1:0] inv_res
);

  function automatic logic [DATA_W-1:0] f_invert(input logic [DATA_W-1:0] v);
    return ~v;
  endfunction

  assign inv_res = f_invert(value_in);

endmodule

// File: rtl/afu_flag_merge.sv
module afu_flag_merge
  import afu_pkg::*;
(
  input  afu_op_e     op,
  input  afu_flags_t  flags_cur,
  input  logic        neg_sign,
  input  logic        neg_zero,
  input  logic        neg_half_borrow,
  input  logic        neg_min_in,
  input  logic        neg_borrow,
  output afu_flags_t  flags_next
);

  always_comb begin
    flags_next = flags_cur;
    case (op)
      OP_INV: begin
        flags_next.h = 1'b1;
        flags_next.n = 1'b1;
      end
      OP_NEG: begin
        flags_next.s  = neg_sign;
        flags_next.z  = neg_zero;
        flags_next.h  = neg_half_borrow;
        flags_next.pv = neg_min_in;
        flags_next.n  = 1'b1;
        flags_next.c  = neg_borrow;
      end
      OP_CINV: begin
        flags_next.h = flags_cur.c;
        flags_next.n = 1'b0;
        flags_next.c = ~flags_cur.c;
      end
      OP_CSET: begin
        flags_next.h = 1'b0;
        flags_next.n = 1'b0;
        flags_next.c = 1'b1;
      end
      default: flags_next = flags_cur;
    endcase
  end

endmodule

// File: rtl/afu_state_count.sv
module afu_state_count
  import afu_pkg::*;
#(
  parameter int STATE_W      = 4,
  parameter int SHORT_STATES = 4,
  parameter int LONG_STATES  = 8
) (
  input  afu_op_e            op,
  output logic [STATE_W-1:0] states
);

  localparam logic [STATE_W-1:0] SHORT_V = STATE_W'(SHORT_STATES);
  localparam logic [STATE_W-1:0] LONG_V  = STATE_W'(LONG_STATES);

  // Only negate carries a second machine cycle.
  assign states = (op == OP_NEG) ? LONG_V : SHORT_V;

endmodule

// File: rtl/acc_flag_unit.sv
module acc_flag_unit
  import afu_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int STATE_W      = 4,
  parameter int SHORT_STATES = 4,
  parameter int LONG_STATES  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               op_valid,
  input  logic [1:0]         op_sel,
  input  logic [DATA_W-1:0]  acc_in,
  input  logic [FLAG_W-1:0]  flags_in,
  output logic [DATA_W-1:0]  acc_out,
  output logic [FLAG_W-1:0]  flags_out,
  output logic [STATE_W-1:0] op_states,
  output logic               res_valid
);

  afu_op_e            op;
  afu_flags_t         flags_cur;
  afu_flags_t         flags_next;
  logic [DATA_W-1:0]  inv_res;
  logic [DATA_W-1:0]  neg_res;
  logic               neg_sign;
  logic               neg_zero;
  logic               neg_half_borrow;
  logic               neg_min_in;
  logic               neg_borrow;
  logic [DATA_W-1:0]  acc_next;
  logic [STATE_W-1:0] states_next;

  logic [DATA_W-1:0]  acc_q;
  logic [FLAG_W-1:0]  flags_q;
  logic [STATE_W-1:0] states_q;
  logic               valid_q;

  assign op        = afu_op_e'(op_sel);
  assign flags_cur = afu_flags_t'(flags_in);

  afu_invert #(.DATA_W(DATA_W)) u_invert (
    .value_in (acc_in),
    .inv_res  (inv_res)
  );

  afu_negate #(.DATA_W(DATA_W)) u_negate (
    .value_in        (acc_in),
    .neg_res         (neg_res),
    .neg_sign        (neg_sign),
    .neg_zero        (neg_zero),
    .neg_half_borrow (neg_half_borrow),
    .neg_min_in      (neg_min_in),
    .neg_borrow      (neg_borrow)
  );

  afu_flag_merge u_flag_merge (
    .op              (op),
    .flags_cur       (flags_cur),
    .neg_sign        (neg_sign),
    .neg_zero        (neg_zero),
    .neg_half_borrow (neg_half_borrow),
    .neg_min_in      (neg_min_in),
    .neg_borrow      (neg_borrow),
    .flags_next      (flags_next)
  );

  afu_state_count #(
    .STATE_W      (STATE_W),
    .SHORT_STATES (SHORT_STATES),
    .LONG_STATES  (LONG_STATES)
  ) u_state_count (
    .op     (op),
    .states (states_next)
  );

  // Carry-only operations pass the accumulator through.
  always_comb begin
    case (op)
      OP_INV:  acc_next = inv_res;
      OP_NEG:  acc_next = neg_res;
      default: acc_next = acc_in;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      flags_q  <= '0;
      states_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= op_valid;
      if (op_valid) begin
        acc_q    <= acc_next;
        flags_q  <= FLAG_W'(flags_next);
        states_q <= states_next;
      end
    end
  end

  assign acc_out   = acc_q;
  assign flags_out = flags_q;
  assign op_states = states_q;
  assign res_valid = valid_q;

endmodule

// File: rtl/afu_checker.sv
module afu_checker
  import afu_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int STATE_W      = 4,
  parameter int SHORT_STATES = 4,
  parameter int LONG_STATES  = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               op_valid,
  input logic [1:0]         op_sel,
  input logic [DATA_W-1:0]  acc_in,
  input logic [FLAG_W-1:0]  flags_in,
  input logic [DATA_W-1:0]  acc_out,
  input logic [FLAG_W-1:0]  flags_out,
  input logic [STATE_W-1:0] op_states,
  input logic               res_valid,
  input logic               neg_min_in
);

  localparam logic [DATA_W-1:0] MIN_VAL = {1'b1, {(DATA_W-1){1'b0}}};

  assert_inv_result_R1: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == 2'b00) |=>
      (acc_out == ~$past(acc_in)) && flags_out[FLAG_H] && flags_out[FLAG_N]
      && (flags_out[FLAG_C] == $past(flags_in[FLAG_C]))
      && (flags_out[FLAG_S] == $past(flags_in[FLAG_S])));

  assert_neg_min_R3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == 2'b01 && neg_min_in) |=>
      (acc_out == MIN_VAL) && flags_out[FLAG_PV]);

  assert_neg_carry_R4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == 2'b01) |=>
      (flags_out[FLAG_C] == ($past(acc_in) != '0)) && flags_out[FLAG_N]);

  assert_cinv_flags_R5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == 2'b10) |=>
      (flags_out[FLAG_C] == !$past(flags_in[FLAG_C]))
      && (flags_out[FLAG_H] == $past(flags_in[FLAG_C])) && !flags_out[FLAG_N]
      && (acc_out == $past(acc_in)));

  assert_cset_flags_R6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == 2'b11) |=>
      flags_out[FLAG_C] && !flags_out[FLAG_H] && !flags_out[FLAG_N]
      && (acc_out == $past(acc_in)));

  assert_state_count_R7: assert property (@(posedge clk) disable iff (rst)
    op_valid |=>
      (op_states == (($past(op_sel) == 2'b01) ? STATE_W'(LONG_STATES)
                                              : STATE_W'(SHORT_STATES))));

  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> res_valid);

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> !res_valid && $stable(acc_out) && $stable(flags_out)
                  && $stable(op_states));

  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (acc_out == '0) && (flags_out == '0) && (op_states == '0) && !res_valid);

endmodule

bind acc_flag_unit afu_checker #(
  .DATA_W       (DATA_W),
  .STATE_W      (STATE_W),
  .SHORT_STATES (SHORT_STATES),
  .LONG_STATES  (LONG_STATES)
) u_afu_checker (
  .clk        (clk),
  .rst        (rst),
  .op_valid   (op_valid),
  .op_sel     (op_sel),
  .acc_in     (acc_in),
  .flags_in   (flags_in),
  .acc_out    (acc_out),
  .flags_out  (flags_out),
  .op_states  (op_states),
  .res_valid  (res_valid),
  .neg_min_in (neg_min_in)
);

// File: tb/acc_flag_unit_tb.sv
`timescale 1ns/1ps
module acc_flag_unit_tb;

  logic       clk = 1'b0;
  logic       rst;
  logic       op_valid;
  logic [1:0] op_sel;
  logic [7:0] acc_in;
  logic [7:0] flags_in;
  logic [7:0] acc_out;
  logic [7:0] flags_out;
  logic [3:0] op_states;
  logic       res_valid;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  acc_flag_unit u_dut (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .op_sel    (op_sel),
    .acc_in    (acc_in),
    .flags_in  (flags_in),
    .acc_out   (acc_out),
    .flags_out (flags_out),
    .op_states (op_states),
    .res_valid (res_valid)
  );

  typedef struct packed {
    logic [1:0] op;
    logic [7:0] a;
    logic [7:0] f;
    logic [7:0] ea;
    logic [7:0] ef;
    logic [3:0] es;
  } vec_t;

  // Flag bits: S7 Z6 s5 H4 s3 PV2 N1 C0.
  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{2'b00, 8'hB4, 8'h00, 8'h4B, 8'h12, 4'd4},  // R1 invert
    '{2'b00, 8'hFF, 8'hED, 8'h00, 8'hFF, 4'd4},  // R1 keeps S Z PV C and spares
    '{2'b01, 8'hED, 8'h00, 8'h13, 8'h13, 4'd8},  // R2 R4 negate
    '{2'b01, 8'h80, 8'h00, 8'h80, 8'h87, 4'd8},  // R3 min value
    '{2'b01, 8'h00, 8'hFF, 8'h00, 8'h6A, 4'd8},  // R4 zero in, no carry
    '{2'b01, 8'h01, 8'h28, 8'hFF, 8'hBB, 4'd8},  // R2 spares kept
    '{2'b01, 8'h10, 8'h00, 8'hF0, 8'h83, 4'd8},  // R2 no half borrow
    '{2'b10, 8'h5A, 8'h01, 8'h5A, 8'h10, 4'd4},  // R5 carry 1->0
    '{2'b10, 8'h33, 8'hD6, 8'h33, 8'hC5, 4'd4},  // R5 carry 0->1
    '{2'b11, 8'hA5, 8'h12, 8'hA5, 8'h01, 4'd4},  // R6
    '{2'b11, 8'h3C, 8'hFE, 8'h3C, 8'hED, 4'd4}   // R6 others kept
  };

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [1:0] op);
    case (op)
      2'b00:   return "R1";
      2'b01:   return "R2/R3/R4";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  // Drive at a falling edge, capture on the rising edge, sample at the next falling edge.
  task automatic drive(input logic [1:0] op, input logic [7:0] a, input logic [7:0] f);
    op_sel   = op;
    acc_in   = a;
    flags_in = f;
    op_valid = 1'b1;
  endtask

  initial begin
    rst = 1'b1; op_valid = 1'b0; op_sel = 2'b00; acc_in = '0; flags_in = '0;
    repeat (3) @(negedge clk);
    chk("R10", "reset acc", acc_out, 8'h00);
    chk("R10", "reset flags", flags_out, 8'h00);
    chk("R10", "reset states", {4'h0, op_states}, 8'h00);
    chk("R10", "reset valid", {7'h0, res_valid}, 8'h00);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i].op, VECS[i].a, VECS[i].f);
      @(negedge clk);
      chk(req_of(VECS[i].op), "acc", acc_out, VECS[i].ea);
      chk(req_of(VECS[i].op), "flags", flags_out, VECS[i].ef);
      chk("R7", "states", {4'h0, op_states}, {4'h0, VECS[i].es});
      chk("R8", "valid", {7'h0, res_valid}, 8'h01);
      op_valid = 1'b0;
    end

    // R9: strobe low, inputs wander; last result (set carry on 3C/FE) must stay.
    for (int k = 0; k < 3; k++) begin
      op_sel = 2'(k); acc_in = 8'h11 * 8'(k + 1); flags_in = 8'h5A ^ 8'(k);
      @(negedge clk);
      chk("R9", "hold acc", acc_out, 8'h3C);
      chk("R9", "hold flags", flags_out, 8'hED);
      chk("R9", "hold states", {4'h0, op_states}, 8'h04);
      chk("R9", "valid low", {7'h0, res_valid}, 8'h00);
    end

    // R8: back-to-back negate of 01 then invert of 0F.
    drive(2'b01, 8'h01, 8'h00);
    @(negedge clk);
    chk("R8", "b2b first acc", acc_out, 8'hFF);
    chk("R8", "b2b first flags", flags_out, 8'h93);
    chk("R8", "b2b first states", {4'h0, op_states}, 8'h08);
    drive(2'b00, 8'h0F, 8'h00);
    @(negedge clk);
    chk("R8", "b2b second acc", acc_out, 8'hF0);
    chk("R8", "b2b second flags", flags_out, 8'h12);
    chk("R8", "b2b second states", {4'h0, op_states}, 8'h04);
    chk("R8", "b2b valid", {7'h0, res_valid}, 8'h01);
    op_valid = 1'b0;
    @(negedge clk);
    chk("R8", "valid drops", {7'h0, res_valid}, 8'h00);

    // R10: reset with a pending negate of 5A.
    drive(2'b01, 8'h5A, 8'hFF);
    rst = 1'b1;
    @(negedge clk);
    chk("R10", "reset wins acc", acc_out, 8'h00);
    chk("R10", "reset wins flags", flags_out, 8'h00);
    chk("R10", "reset wins states", {4'h0, op_states}, 8'h00);
    chk("R10", "reset wins valid", {7'h0, res_valid}, 8'h00);
    op_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule